// File: doc/BRIEF.md
# Parallel Strobe/Acknowledge Byte Port

This block moves 8-bit bytes across a parallel printer-style link that uses three handshake wires: a strobe that qualifies the data, an acknowledge that confirms a byte, and a busy flag that holds the far side off. A direction setting makes the port a receiver or a transmitter. Toward internal logic it offers a valid/ready byte interface in each direction. A single write-enable control input loads the whole configuration at once. That configuration covers direction, handshake mode, busy-release policy, transmit busy gating, and the acknowledge and strobe pulse widths.

Four handshake modes are encoded in a 2-bit field. In the plain I/O mode the handshake is switched off. The transparent mode only strobes or captures. The interlocked mode holds each handshake line until the far side answers. The pulsed mode uses timed pulses. In pulsed receive mode, a 2-bit release field picks when BUSY is dropped relative to the ACK pulse. One choice waits for a software release pulse. In transmit mode, an optional gate holds the strobe off while the peripheral reports busy. The STB, ACK and BUSY inputs each pass through a two-flop synchroniser. The receiver FSM has the states RX_IDLE, RX_HOLD, RX_LEAD, RX_ACK_FIRST, RX_ACK_REST, RX_TRAIL, RX_SW_WAIT and RX_ILK_ACK. The transmitter FSM has the states TX_IDLE, TX_SETUP, TX_STB, TX_ILK, TX_ACK_LO and TX_ACK_HI.

Receiver transitions:
- RX_IDLE to RX_HOLD on a strobe fall.
- RX_HOLD on accept: to RX_IDLE in transparent mode, to RX_ILK_ACK in interlocked mode, to RX_LEAD (release 00) or RX_ACK_FIRST (other releases) in pulsed mode.
- RX_LEAD to RX_ACK_FIRST.
- RX_ACK_FIRST to RX_ACK_REST, or to the exit target when the width is 1.
- RX_ACK_REST to the exit target when its counter ends. The exit target is RX_TRAIL (release 10), RX_SW_WAIT (release 11) or RX_IDLE (releases 00 and 01).
- RX_TRAIL to RX_IDLE.
- RX_SW_WAIT to RX_IDLE on the release pulse.
- RX_ILK_ACK to RX_IDLE when the strobe is high again.

Transmitter transitions:
- TX_IDLE to TX_SETUP on accept.
- TX_SETUP to TX_STB when the gate allows.
- TX_STB, at the end of its count, to TX_IDLE (transparent), TX_ILK (interlocked) or TX_ACK_LO (pulsed).
- TX_ILK and TX_ACK_LO to TX_ACK_HI on ACK low.
- TX_ACK_HI to TX_IDLE on ACK high.

Top module: `par_hs_port`

## Requirements
- R1: Mode code 00 disables the handshake. BUSY stays 0, ACK and STB outputs stay high (negated), the data output enable stays 0, rx_valid stays 0 and tx_ready stays 0, whatever the pins do. This is the state after reset.
- R2: When receiving in a handshake mode (01, 10, 11), a high-to-low strobe is detected after the two-flop synchroniser. On the third rising clock edge after the pin falls, the byte on the data pins is latched into rx_data and rx_valid is raised. On that same edge BUSY goes to 1 in modes 10 and 11. rx_data and rx_valid hold until rx_ready is sampled high.
- R3: Transparent receive (mode 01) never drives BUSY or ACK, and the port returns to idle on the accept edge.
- R4: Interlocked receive (mode 10) drives ACK low from the edge after the accept until the edge after the synchronised strobe is seen high again. That is three edges after the strobe pin rises. ACK and BUSY are then released together.
- R5: In pulsed receive with release code 00, BUSY falls on the accept edge. ACK is then low for W cycles, starting one cycle later, where W is the programmed ACK width and a width of 0 counts as 1.
- R6: In pulsed receive with release code 01, ACK is low for max(W,2) cycles from the edge after the accept, and BUSY falls after the first of those cycles.
- R7: In pulsed receive with release code 10, BUSY stays 1 through the ACK pulse and for one cycle after ACK rises.
- R8: In pulsed receive with release code 11, BUSY stays 1 after the ACK pulse until a one-cycle sw_release pulse. BUSY falls on the edge that samples that pulse.
- R9: The release code has no effect unless the port is receiving in pulsed mode. With code 11 in interlocked receive, no software release is needed.
- R10: In transmit direction with a handshake mode, the accepted byte drives the data pins with the output enable set. STB stays high for one setup cycle and is then low for S cycles, where S is the strobe width and 0 counts as 1. In transparent mode tx_ready returns on the next cycle. While transmitting, ACK and BUSY outputs stay negated.
- R11: In pulsed transmit, after the strobe the port waits for the ACK pin to go low and then high again. tx_ready returns three edges after ACK rises.
- R12: In interlocked transmit, STB stays low past its minimum width until ACK is seen low. STB rises three edges after the ACK pin falls.
- R13: With the busy gate set, STB does not fall while the synchronised BUSY input is 1. It falls on the third edge after BUSY drops. With the gate clear, BUSY has no effect.
- R14: A configuration write while either FSM is away from idle is ignored as a whole. A write while both are idle takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write enable |
| cfg_dir_tx | input | 1 | 1 = transmitter, 0 = receiver |
| cfg_mode | input | 2 | Handshake mode: 00 off, 01 transparent, 10 interlocked, 11 pulsed |
| cfg_rel | input | 2 | Busy-release policy for pulsed receive |
| cfg_gate | input | 1 | Transmit busy gate enable |
| cfg_ack_w | input | PW | ACK pulse width in cycles (0 means 1) |
| cfg_stb_w | input | PW | STB pulse width in cycles (0 means 1) |
| sw_release | input | 1 | Software busy release pulse |
| rx_data | output | DW | Received byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Internal logic takes the received byte |
| tx_data | input | DW | Byte to send |
| tx_valid | input | 1 | Byte to send available |
| tx_ready | output | 1 | Transmitter can take a byte |
| pin_data_in | input | DW | Data pins as input |
| pin_data_out | output | DW | Data pins as output |
| pin_data_oe | output | 1 | Data pin output enable |
| pin_stb_n_in | input | 1 | Strobe from host, active low |
| pin_stb_n_out | output | 1 | Strobe to peripheral, active low |
| pin_ack_n_in | input | 1 | Acknowledge from peripheral, active low |
| pin_ack_n_out | output | 1 | Acknowledge to host, active low |
| pin_busy_in | input | 1 | Busy from peripheral |
| pin_busy_out | output | 1 | Busy to host |

## Verification
A strobe, ACK or BUSY change on a pin shows up at the outputs on the third rising edge. Two edges are spent in the synchroniser and one in the state register. The bench checks one edge earlier that the output has not yet moved, and checks again on the expected edge. Results that follow an internal accept, such as the ACK and BUSY sequence, the setup cycle and the strobe pulse, are counted from the accept edge. Bench functions compute the expected ACK and BUSY level for each cycle index k after that edge. Every sample is taken 1 ns after a rising edge, and inputs are changed at that same point.

// File: rtl/par_hs_pkg.sv
`timescale 1ns/1ps
package par_hs_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_TRANSP = 2'b01,
        MODE_ILOCK  = 2'b10,
        MODE_PULSE  = 2'b11
    } hs_mode_e;

    typedef enum logic [1:0] {
        REL_BEFORE = 2'b00,
        REL_DURING = 2'b01,
        REL_AFTER  = 2'b10,
        REL_SW     = 2'b11
    } rel_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_HOLD,
        RX_LEAD,
        RX_ACK_FIRST,
        RX_ACK_REST,
        RX_TRAIL,
        RX_SW_WAIT,
        RX_ILK_ACK
    } rx_state_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SETUP,
        TX_STB,
        TX_ILK,
        TX_ACK_LO,
        TX_ACK_HI
    } tx_state_e;

endpackage

// File: rtl/par_hs_sync.sv
`timescale 1ns/1ps
module par_hs_sync #(
    parameter int             N       = 3,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [N-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= RST_VAL;
                else        stage_q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/par_hs_rx.sv
`timescale 1ns/1ps
module par_hs_rx
    import par_hs_pkg::*;
#(
    parameter int DW = 8,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  hs_mode_e      mode,
    input  rel_e          rel,
    input  logic [PW-1:0] ack_w,
    input  logic          stb_s,
    input  logic          stb_fall,
    input  logic [DW-1:0] pin_data,
    input  logic          sw_release,
    input  logic          rx_ready,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          busy_out,
    output logic          ack_n_out,
    output logic          idle
);

    localparam logic [PW-1:0] W_ONE = PW'(1);
    localparam logic [PW-1:0] W_TWO = PW'(2);

    rx_state_e     st_q, st_d;
    logic [PW-1:0] cnt_q, cnt_d;
    logic [PW-1:0] len;
    logic [DW-1:0] data_q;
    rx_state_e     ack_exit;

    // effective acknowledge width
    always_comb begin
        len = (ack_w == '0) ? W_ONE : ack_w;
        if (rel == REL_DURING && len < W_TWO) len = W_TWO;
    end

    always_comb begin
        unique case (rel)
            REL_AFTER:  ack_exit = RX_TRAIL;
            REL_SW:     ack_exit = RX_SW_WAIT;
            REL_BEFORE,
            REL_DURING: ack_exit = RX_IDLE;
            default:    ack_exit = RX_IDLE;
        endcase
    end

    // state register and byte latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RX_IDLE;
            cnt_q  <= '0;
            data_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (st_q == RX_IDLE && st_d == RX_HOLD) data_q <= pin_data;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            RX_IDLE: begin
                if (en && stb_fall) st_d = RX_HOLD;
            end
            RX_HOLD: begin
                if (rx_ready) begin
                    unique case (mode)
                        MODE_TRANSP: st_d = RX_IDLE;
                        MODE_ILOCK:  st_d = RX_ILK_ACK;
                        MODE_PULSE:  st_d = (rel == REL_BEFORE) ? RX_LEAD : RX_ACK_FIRST;
                        MODE_OFF:    st_d = RX_IDLE;
                        default:     st_d = RX_IDLE;
                    endcase
                end
            end
            RX_LEAD: st_d = RX_ACK_FIRST;
            RX_ACK_FIRST: begin
                if (len == W_ONE) begin
                    st_d = ack_exit;
                end else begin
                    st_d  = RX_ACK_REST;
                    cnt_d = len - W_TWO;
                end
            end
            RX_ACK_REST: begin
                if (cnt_q == '0) st_d = ack_exit;
                else             cnt_d = cnt_q - W_ONE;
            end
            RX_TRAIL:   st_d = RX_IDLE;
            RX_SW_WAIT: begin
                if (sw_release) st_d = RX_IDLE;
            end
            RX_ILK_ACK: begin
                if (stb_s) st_d = RX_IDLE;
            end
            default: st_d = RX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rx_valid  = 1'b0;
        busy_out  = 1'b0;
        ack_n_out = 1'b1;
        unique case (st_q)
            RX_IDLE:      ;
            RX_HOLD: begin
                rx_valid = 1'b1;
                busy_out = (mode != MODE_TRANSP);
            end
            RX_LEAD:      ;
            RX_ACK_FIRST: begin
                ack_n_out = 1'b0;
                busy_out  = (rel != REL_BEFORE);
            end
            RX_ACK_REST: begin
                ack_n_out = 1'b0;
                busy_out  = (rel == REL_AFTER) || (rel == REL_SW);
            end
            RX_TRAIL:     busy_out = 1'b1;
            RX_SW_WAIT:   busy_out = 1'b1;
            RX_ILK_ACK: begin
                ack_n_out = 1'b0;
                busy_out  = 1'b1;
            end
            default:      ;
        endcase
    end

    assign rx_data = data_q;
    assign idle    = (st_q == RX_IDLE);

endmodule

// File: rtl/par_hs_tx.sv
`timescale 1ns/1ps
module par_hs_tx
    import par_hs_pkg::*;
#(
    parameter int DW = 8,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  hs_mode_e      mode,
    input  logic          gate,
    input  logic [PW-1:0] stb_w,
    input  logic          busy_s,
    input  logic          ack_s,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    output logic [DW-1:0] data_out,
    output logic          stb_n_out,
    output logic          idle
);

    localparam logic [PW-1:0] W_ONE = PW'(1);

    tx_state_e     st_q, st_d;
    logic [PW-1:0] cnt_q, cnt_d;
    logic [PW-1:0] len;
    logic [DW-1:0] data_q;

    assign len = (stb_w == '0) ? W_ONE : stb_w;

    // state register and byte latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= TX_IDLE;
            cnt_q  <= '0;
            data_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (st_q == TX_IDLE && st_d == TX_SETUP) data_q <= tx_data;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            TX_IDLE: begin
                if (en && tx_valid) st_d = TX_SETUP;
            end
            TX_SETUP: begin
                if (!(gate && busy_s)) begin
                    st_d  = TX_STB;
                    cnt_d = len - W_ONE;
                end
            end
            TX_STB: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - W_ONE;
                end else begin
                    unique case (mode)
                        MODE_ILOCK:  st_d = TX_ILK;
                        MODE_PULSE:  st_d = TX_ACK_LO;
                        MODE_TRANSP: st_d = TX_IDLE;
                        MODE_OFF:    st_d = TX_IDLE;
                        default:     st_d = TX_IDLE;
                    endcase
                end
            end
            TX_ILK: begin
                if (!ack_s) st_d = TX_ACK_HI;
            end
            TX_ACK_LO: begin
                if (!ack_s) st_d = TX_ACK_HI;
            end
            TX_ACK_HI: begin
                if (ack_s) st_d = TX_IDLE;
            end
            default: st_d = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_ready  = 1'b0;
        stb_n_out = 1'b1;
        unique case (st_q)
            TX_IDLE:   tx_ready  = en;
            TX_SETUP:  ;
            TX_STB:    stb_n_out = 1'b0;
            TX_ILK:    stb_n_out = 1'b0;
            TX_ACK_LO: ;
            TX_ACK_HI: ;
            default:   ;
        endcase
    end

    assign data_out = data_q;
    assign idle     = (st_q == TX_IDLE);

endmodule

// File: rtl/par_hs_port.sv
`timescale 1ns/1ps
module par_hs_port
    import par_hs_pkg::*;
#(
    parameter int DW          = 8,
    parameter int PW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_dir_tx,
    input  logic [1:0]    cfg_mode,
    input  logic [1:0]    cfg_rel,
    input  logic          cfg_gate,
    input  logic [PW-1:0] cfg_ack_w,
    input  logic [PW-1:0] cfg_stb_w,
    input  logic          sw_release,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    input  logic          rx_ready,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    input  logic [DW-1:0] pin_data_in,
    output logic [DW-1:0] pin_data_out,
    output logic          pin_data_oe,
    input  logic          pin_stb_n_in,
    output logic          pin_stb_n_out,
    input  logic          pin_ack_n_in,
    output logic          pin_ack_n_out,
    input  logic          pin_busy_in,
    output logic          pin_busy_out
);

    localparam int NSYNC = 3;

    // configuration held while either side is busy
    logic          r_dir_tx;
    hs_mode_e      r_mode;
    rel_e          r_rel;
    logic          r_gate;
    logic [PW-1:0] r_ack_w;
    logic [PW-1:0] r_stb_w;

    logic             rx_idle, tx_idle;
    logic             en_rx, en_tx;
    logic [NSYNC-1:0] sync_out;
    logic             stb_s, ack_s, busy_s;
    logic             stb_prev;
    logic             stb_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_dir_tx <= 1'b0;
            r_mode   <= MODE_OFF;
            r_rel    <= REL_BEFORE;
            r_gate   <= 1'b0;
            r_ack_w  <= PW'(1);
            r_stb_w  <= PW'(1);
        end else if (cfg_wr && rx_idle && tx_idle) begin
            r_dir_tx <= cfg_dir_tx;
            r_mode   <= hs_mode_e'(cfg_mode);
            r_rel    <= rel_e'(cfg_rel);
            r_gate   <= cfg_gate;
            r_ack_w  <= cfg_ack_w;
            r_stb_w  <= cfg_stb_w;
        end
    end

    assign en_rx = !r_dir_tx && (r_mode != MODE_OFF);
    assign en_tx =  r_dir_tx && (r_mode != MODE_OFF);

    par_hs_sync #(
        .N       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({pin_stb_n_in, pin_ack_n_in, pin_busy_in}),
        .dout  (sync_out)
    );

    assign stb_s  = sync_out[2];
    assign ack_s  = sync_out[1];
    assign busy_s = sync_out[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_prev <= 1'b1;
        else        stb_prev <= stb_s;
    end

    assign stb_fall = stb_prev && !stb_s;

    par_hs_rx #(
        .DW (DW),
        .PW (PW)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_rx),
        .mode       (r_mode),
        .rel        (r_rel),
        .ack_w      (r_ack_w),
        .stb_s      (stb_s),
        .stb_fall   (stb_fall),
        .pin_data   (pin_data_in),
        .sw_release (sw_release),
        .rx_ready   (rx_ready),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .busy_out   (pin_busy_out),
        .ack_n_out  (pin_ack_n_out),
        .idle       (rx_idle)
    );

    par_hs_tx #(
        .DW (DW),
        .PW (PW)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_tx),
        .mode      (r_mode),
        .gate      (r_gate),
        .stb_w     (r_stb_w),
        .busy_s    (busy_s),
        .ack_s     (ack_s),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .data_out  (pin_data_out),
        .stb_n_out (pin_stb_n_out),
        .idle      (tx_idle)
    );

    assign pin_data_oe = en_tx;

endmodule

// File: rtl/par_hs_port_chk.sv
`timescale 1ns/1ps
module par_hs_port_chk
    import par_hs_pkg::*;
#(
    parameter int DW = 8,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          r_dir_tx,
    input hs_mode_e      r_mode,
    input rel_e          r_rel,
    input logic          r_gate,
    input logic          busy_s,
    input logic          rx_idle,
    input logic          tx_idle,
    input logic          sw_release,
    input logic [DW-1:0] rx_data,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          tx_ready,
    input logic          pin_data_oe,
    input logic          pin_stb_n_out,
    input logic          pin_ack_n_out,
    input logic          pin_busy_out
);

    logic pulse_rx;
    assign pulse_rx = !r_dir_tx && (r_mode == MODE_PULSE);

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_mode == MODE_OFF) |-> (!pin_busy_out && pin_ack_n_out && pin_stb_n_out
                                  && !pin_data_oe && !rx_valid && !tx_ready))
        else $error("off mode drives handshake");

    assert_rx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)))
        else $error("received byte not held");

    assert_rel_before_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_rx && r_rel == REL_BEFORE && !pin_ack_n_out) |-> !pin_busy_out)
        else $error("busy high during ack with early release");

    assert_rel_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_rx && r_rel == REL_AFTER && $rose(pin_ack_n_out)) |-> pin_busy_out)
        else $error("busy low when ack ends with late release");

    assert_sw_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_rx && r_rel == REL_SW && $fell(pin_busy_out)) |-> $past(sw_release))
        else $error("busy dropped without software release");

    assert_tx_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pin_data_oe |-> (pin_ack_n_out && !pin_busy_out))
        else $error("receive handshake active while transmitting");

    assert_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (r_gate && $fell(pin_stb_n_out)) |-> !$past(busy_s))
        else $error("strobe while peripheral busy");

    assert_cfg_lock_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_idle || !tx_idle) |=> ($stable(r_mode) && $stable(r_dir_tx) && $stable(r_rel)))
        else $error("configuration changed mid transfer");

endmodule

bind par_hs_port par_hs_port_chk #(
    .DW (DW),
    .PW (PW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .r_dir_tx      (r_dir_tx),
    .r_mode        (r_mode),
    .r_rel         (r_rel),
    .r_gate        (r_gate),
    .busy_s        (busy_s),
    .rx_idle       (rx_idle),
    .tx_idle       (tx_idle),
    .sw_release    (sw_release),
    .rx_data       (rx_data),
    .rx_valid      (rx_valid),
    .rx_ready      (rx_ready),
    .tx_ready      (tx_ready),
    .pin_data_oe   (pin_data_oe),
    .pin_stb_n_out (pin_stb_n_out),
    .pin_ack_n_out (pin_ack_n_out),
    .pin_busy_out  (pin_busy_out)
);

// File: tb/tb_par_hs_port.sv
`timescale 1ns/1ps
module tb_par_hs_port;

    localparam int DW = 8;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_wr, cfg_dir_tx, cfg_gate, sw_release;
    logic [1:0]    cfg_mode, cfg_rel;
    logic [PW-1:0] cfg_ack_w, cfg_stb_w;
    logic [DW-1:0] rx_data, tx_data, pin_data_in, pin_data_out;
    logic          rx_valid, rx_ready, tx_valid, tx_ready;
    logic          pin_data_oe, pin_stb_n_in, pin_stb_n_out;
    logic          pin_ack_n_in, pin_ack_n_out, pin_busy_in, pin_busy_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    par_hs_port #(.DW(DW), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dir_tx(cfg_dir_tx),
        .cfg_mode(cfg_mode), .cfg_rel(cfg_rel), .cfg_gate(cfg_gate),
        .cfg_ack_w(cfg_ack_w), .cfg_stb_w(cfg_stb_w), .sw_release(sw_release),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .pin_data_in(pin_data_in), .pin_data_out(pin_data_out), .pin_data_oe(pin_data_oe),
        .pin_stb_n_in(pin_stb_n_in), .pin_stb_n_out(pin_stb_n_out),
        .pin_ack_n_in(pin_ack_n_in), .pin_ack_n_out(pin_ack_n_out),
        .pin_busy_in(pin_busy_in), .pin_busy_out(pin_busy_out)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // expected values
    function automatic int eff_w(int aw, int rel);
        int w = (aw == 0) ? 1 : aw;
        if (rel == 1 && w < 2) w = 2;
        return w;
    endfunction

    function automatic int exp_ack_low(int rel, int w, int k);
        if (rel == 0) return int'(k >= 2 && k <= w + 1);
        return int'(k >= 1 && k <= w);
    endfunction

    function automatic int exp_busy(int rel, int w, int k);
        case (rel)
            0:       return 0;
            1:       return int'(k == 1);
            2:       return int'(k <= w + 1);
            default: return 1;
        endcase
    endfunction

    function automatic string rel_tag(int rel);
        case (rel)
            0:       return "R5";
            1:       return "R6";
            2:       return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic cfg(bit dtx, int md, int rl, bit gt, int aw, int sw);
        cfg_dir_tx = dtx;
        cfg_mode   = 2'(md);
        cfg_rel    = 2'(rl);
        cfg_gate   = gt;
        cfg_ack_w  = PW'(aw);
        cfg_stb_w  = PW'(sw);
        cfg_wr     = 1'b1;
        tick();
        cfg_wr     = 1'b0;
    endtask

    // strobe a byte in; rx_valid is due on the third edge
    task automatic rx_start(logic [7:0] b, int busy_exp, bit raise, string tag);
        pin_data_in  = b;
        pin_stb_n_in = 1'b0;
        tick(); tick();
        chk({tag, " valid early"}, int'(rx_valid), 0);
        tick();
        chk({tag, " valid"}, int'(rx_valid), 1);
        chk({tag, " data"}, int'(rx_data), int'(b));
        chk({tag, " busy on capture"}, int'(pin_busy_out), busy_exp);
        pin_data_in = ~b;
        if (raise) pin_stb_n_in = 1'b1;
    endtask

    task automatic rx_pulsed_run(int rel, int aw, string tag);
        int w = eff_w(aw, rel);
        rx_ready = 1'b1;
        tick();
        rx_ready = 1'b0;
        for (int k = 1; k <= w + 3; k++) begin
            chk({tag, " ack"}, int'(!pin_ack_n_out), exp_ack_low(rel, w, k));
            chk({tag, " busy"}, int'(pin_busy_out), exp_busy(rel, w, k));
            tick();
        end
        if (rel == 3) begin
            chk("R8 busy waits", int'(pin_busy_out), 1);
            sw_release = 1'b1;
            tick();
            sw_release = 1'b0;
            chk("R8 busy released", int'(pin_busy_out), 0);
        end
        tick();
    endtask

    task automatic tx_strobe(logic [7:0] b, int sw, string tag);
        int s = (sw == 0) ? 1 : sw;
        chk({tag, " ready"}, int'(tx_ready), 1);
        tx_data  = b;
        tx_valid = 1'b1;
        tick();
        tx_valid = 1'b0;
        chk({tag, " setup stb high"}, int'(pin_stb_n_out), 1);
        chk({tag, " data"}, int'(pin_data_out), int'(b));
        chk({tag, " oe"}, int'(pin_data_oe), 1);
        for (int k = 2; k <= s + 1; k++) begin
            tick();
            chk({tag, " stb low"}, int'(pin_stb_n_out), 0);
        end
        tick();
        chk({tag, " stb end"}, int'(pin_stb_n_out), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd90210);
        rst_n = 0; cfg_wr = 0; cfg_dir_tx = 0; cfg_mode = 0; cfg_rel = 0; cfg_gate = 0;
        cfg_ack_w = 1; cfg_stb_w = 1; sw_release = 0; rx_ready = 0; tx_valid = 0;
        tx_data = 0; pin_data_in = 0; pin_stb_n_in = 1; pin_ack_n_in = 1; pin_busy_in = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R1: reset state is handshake off
        chk("R1 reset busy", int'(pin_busy_out), 0);
        chk("R1 reset ack", int'(pin_ack_n_out), 1);
        chk("R1 reset stb", int'(pin_stb_n_out), 1);
        chk("R1 reset oe", int'(pin_data_oe), 0);
        pin_stb_n_in = 0;
        tx_valid = 1;
        repeat (5) tick();
        chk("R1 no capture", int'(rx_valid), 0);
        chk("R1 no busy", int'(pin_busy_out), 0);
        chk("R1 no tx ready", int'(tx_ready), 0);
        tx_valid = 0;
        pin_stb_n_in = 1;
        repeat (3) tick();

        // R3: transparent receive
        cfg(0, 1, 0, 0, 2, 1);
        rx_start(8'h3C, 0, 1, "R3");
        rx_ready = 1; tick(); rx_ready = 0;
        for (int k = 0; k < 3; k++) begin
            chk("R3 ack stays high", int'(pin_ack_n_out), 1);
            chk("R3 busy stays low", int'(pin_busy_out), 0);
            chk("R3 idle after accept", int'(rx_valid), 0);
            tick();
        end

        // R4 and R9: interlocked receive with release code 11
        cfg(0, 2, 3, 0, 1, 1);
        rx_start(8'hA5, 1, 0, "R4");
        rx_ready = 1; tick(); rx_ready = 0;
        chk("R4 ack low", int'(pin_ack_n_out), 0);
        repeat (3) tick();
        chk("R4 ack held", int'(pin_ack_n_out), 0);
        pin_stb_n_in = 1;
        tick(); tick();
        chk("R4 ack before strobe seen", int'(pin_ack_n_out), 0);
        tick();
        chk("R4 ack released", int'(pin_ack_n_out), 1);
        chk("R9 busy released without software", int'(pin_busy_out), 0);
        tick();

        // R14: write during a transfer is dropped
        cfg(0, 3, 0, 0, 2, 1);
        rx_start(8'h81, 1, 1, "R14 pulsed");
        cfg(0, 1, 0, 0, 1, 1);
        chk("R14 still holding", int'(rx_valid), 1);
        rx_pulsed_run(0, 2, "R14 pulsed kept");
        cfg(0, 1, 0, 0, 1, 1);
        rx_start(8'h18, 0, 1, "R14 write taken");
        rx_ready = 1; tick(); rx_ready = 0; tick();

        // R5..R8: pulsed receive, directed corners then random
        for (int rl = 0; rl < 4; rl++) begin
            cfg(0, 3, rl, 0, 0, 1);
            rx_start(8'(8'h10 + rl), 1, 1, rel_tag(rl));
            repeat (2) tick();
            chk("R2 held without ready", int'(rx_valid), 1);
            chk("R2 data stable", int'(rx_data), 8'h10 + rl);
            rx_pulsed_run(rl, 0, rel_tag(rl));
        end
        for (int i = 0; i < 24; i++) begin
            int rl = int'($urandom % 4);
            int aw = int'($urandom % 6);
            logic [7:0] b = 8'($urandom);
            cfg(0, 3, rl, 0, aw, 1);
            rx_start(b, 1, 1, rel_tag(rl));
            repeat (int'($urandom % 3)) tick();
            rx_pulsed_run(rl, aw, rel_tag(rl));
        end

        // R10: transmit transparent
        cfg(1, 1, 3, 0, 1, 3);
        chk("R10 rx lines idle in tx", int'(pin_ack_n_out), 1);
        tx_strobe(8'h5A, 3, "R10");
        chk("R10 ready again", int'(tx_ready), 1);

        // R10 and R11: pulsed transmit with random widths
        for (int i = 0; i < 8; i++) begin
            int sw = int'($urandom % 5);
            cfg(1, 3, 0, 0, 1, sw);
            tx_strobe(8'($urandom), sw, "R10 pulsed");
            chk("R11 waits for ack", int'(tx_ready), 0);
            pin_ack_n_in = 0;
            tick(); tick(); tick();
            chk("R11 still waiting", int'(tx_ready), 0);
            pin_ack_n_in = 1;
            tick(); tick();
            chk("R11 not yet ready", int'(tx_ready), 0);
            tick();
            chk("R11 ready after ack", int'(tx_ready), 1);
        end

        // R12: interlocked transmit
        cfg(1, 2, 0, 0, 1, 1);
        tx_data = 8'hC3; tx_valid = 1; tick(); tx_valid = 0;
        tick();
        chk("R12 stb low", int'(pin_stb_n_out), 0);
        repeat (3) tick();
        chk("R12 stb held", int'(pin_stb_n_out), 0);
        pin_ack_n_in = 0;
        tick(); tick();
        chk("R12 stb before ack seen", int'(pin_stb_n_out), 0);
        tick();
        chk("R12 stb released", int'(pin_stb_n_out), 1);
        pin_ack_n_in = 1;
        repeat (3) tick();
        chk("R12 ready", int'(tx_ready), 1);

        // R13: busy gate
        pin_busy_in = 1;
        cfg(1, 1, 0, 1, 1, 1);
        repeat (3) tick();
        tx_data = 8'h99; tx_valid = 1; tick(); tx_valid = 0;
        for (int k = 0; k < 5; k++) begin
            chk("R13 held off", int'(pin_stb_n_out), 1);
            tick();
        end
        pin_busy_in = 0;
        tick(); tick();
        chk("R13 still off", int'(pin_stb_n_out), 1);
        tick();
        chk("R13 strobe after busy drops", int'(pin_stb_n_out), 0);
        repeat (3) tick();
        pin_busy_in = 1;
        cfg(1, 1, 0, 0, 1, 1);
        repeat (3) tick();
        tx_strobe(8'h66, 1, "R13 gate clear");
        pin_busy_in = 0;
        tick();

        finish_run();
    end

endmodule